// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave side of a four-wire host control link. The host provides a control clock, an active-low select, a serial data line into the block, and a serial data line out of it. The block turns this serial traffic into write strobes and read requests on a parallel register bus. The register storage itself sits outside the block. The control clock, select and data lines are sampled by the block's own system clock, which must run several times faster than the control clock. Delivering them as signals already synchronous to that system clock is the integrator's job.

Each transaction opens with a command byte. Its most significant bit gives the direction (0 = write, 1 = read). The next bit is a length flag (1 = a data byte follows, 0 = command only). The low six bits are the register address. All bytes travel most significant bit first. Input bits are taken on rising control-clock edges. The output line moves on falling edges and is enabled only while the data byte of a read is being clocked with select low. This lets the host tie the input and output lines together. The command byte and its data byte may share one 16-clock select window or sit in two separate 8-clock windows. A command byte with the length flag clear does nothing and only puts the framing back in step. If select rises in the middle of a byte, that byte is thrown away and the port waits for a command byte.

The controller has four states. `ST_CMD` collects a command byte. `ST_WR_DATA` collects write data. `ST_RD_FETCH` lasts one cycle and takes the read value from the register bus. `ST_RD_DATA` shifts that value out. The transitions are:
- `ST_CMD` to `ST_WR_DATA` on a complete write command with the length flag set.
- `ST_CMD` to `ST_RD_FETCH` on a complete read command with the length flag set.
- `ST_CMD` to `ST_CMD` on a complete command with the length flag clear.
- `ST_RD_FETCH` to `ST_RD_DATA` always, after one cycle.
- `ST_WR_DATA` and `ST_RD_DATA` back to `ST_CMD` when the data byte completes, or when select rises mid-byte.

Top module: `sport_top`

## Requirements
- R1: After reset, `sdo_oe_o`, `wr_stb_o` and `rd_req_o` are all low, and the first byte clocked in is treated as a command.
- R2: Bit 7 of the command byte selects the direction (0 write, 1 read). Bit 6 is the length flag (1 = a data byte follows). Bits 5..0 are the address. Bytes are sent MSB first and each bit is taken on a rising edge of `sclk_i` while `csn_i` is low.
- R3: After a write command with the length flag set, the next complete byte causes exactly one single-cycle `wr_stb_o` pulse. During that pulse `reg_addr_o` holds the command's address and `wr_data_o` holds the data byte.
- R4: A complete read command with the length flag set raises `rd_req_o` for exactly one cycle, with the address on `reg_addr_o`. The value on `rd_data_i` in that cycle is the value that is returned.
- R5: The read value appears on `sdo_o` MSB first. Its first bit is valid before the first rising edge of the data byte, and each later bit changes only after a falling edge of `sclk_i`.
- R6: `sdo_oe_o` is high only while the data byte of a read is in progress with `csn_i` low. It is low during command bytes, during write data, and whenever `csn_i` is high.
- R7: A transaction completes identically whether its command and data bytes come in two separate select windows or back to back in one 16-clock window.
- R8: A command byte with the length flag clear produces no strobe and no read request, and the byte after it is treated as a command.
- R9: If `csn_i` rises after 1 to 7 bits of a byte, those bits are discarded, no strobe is issued, and the port goes back to expecting a command byte.
- R10: Edges on `sclk_i` while `csn_i` is high have no effect.
- R11: Once a data byte completes, the next byte, even within the same select window, is taken as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `sclk_i` |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host control clock, synchronous to `clk` |
| csn_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (drive the pad when high) |
| wr_stb_o | output | 1 | Single-cycle register write strobe |
| rd_req_o | output | 1 | Single-cycle register read request |
| reg_addr_o | output | 6 | Register address for writes and reads |
| wr_data_o | output | 8 | Register write data |
| rd_data_i | input | 8 | Register read data, valid while `rd_req_o` is high |

## Verification
The bench checks how the two framings interact. It runs each transaction both as split windows and as a single 16-clock window. If the design reset its byte framing on every select edge, split transactions would be lost. If it failed to stay in a data state across a select gap, commands would be taken as data. It truncates both command and data bytes with an early select rise. A design that kept the partial count would misalign every later byte and write or read the wrong register. The bench also sends command-only bytes, toggles the clock with select high, and packs back-to-back transactions into one window. It watches every cycle for the output enable being raised outside a read data byte, which on a shared wire would collide with the host's own data.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int SPORT_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_CMD      = 2'd0,
        ST_WR_DATA  = 2'd1,
        ST_RD_FETCH = 2'd2,
        ST_RD_DATA  = 2'd3
    } sport_state_e;

endpackage

// File: rtl/sport_edge.sv
module sport_edge #(
    parameter int             N    = 2,
    parameter logic [N-1:0]   IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] lvl_q;

    for (genvar g = 0; g < N; g++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q[g] <= IDLE[g];
            end else begin
                lvl_q[g] <= lvl_i[g];
            end
        end
        assign rise_o[g] = lvl_i[g] & ~lvl_q[g];
        assign fall_o[g] = ~lvl_i[g] & lvl_q[g];
    end

endmodule

// File: rtl/sport_rx.sv
module sport_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_i,
    input  logic         rise_i,
    input  logic         bit_i,
    output logic [W-1:0] byte_o,
    output logic         done_o,
    output logic         partial_o
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic [W-1:0]  shift_q;

    // Complete byte as seen on the edge that brings in the last bit
    assign byte_o    = {shift_q[W-2:0], bit_i};
    assign done_o    = sel_i && rise_i && (cnt_q == LAST);
    assign partial_o = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (!sel_i) begin
            cnt_q   <= '0;
        end else if (rise_i) begin
            shift_q <= byte_o;
            cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sport_tx.sv
module sport_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    output logic         bit_o
);

    logic [W-1:0] shift_q;

    assign bit_o = shift_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load_i) begin
            shift_q <= load_val_i;
        end else if (shift_i) begin
            shift_q <= {shift_q[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int BYTE_W = SPORT_BYTE_W,
    parameter int ADDR_W = BYTE_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              wr_stb_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    input  logic [BYTE_W-1:0] rd_data_i
);

    localparam int DIR_BIT = BYTE_W - 1;
    localparam int LEN_BIT = BYTE_W - 2;

    sport_state_e state_q, state_d;

    logic [1:0] edge_rise, edge_fall;
    logic       sclk_rise, sclk_fall, csn_rise;
    logic       sel;

    logic [BYTE_W-1:0] rx_byte;
    logic              rx_done, rx_partial;

    logic cmd_read, cmd_long;
    logic [ADDR_W-1:0] cmd_addr;
    logic abort;

    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              wr_stb_q;
    logic              tx_load, tx_shift;

    // Edge detection on control clock (bit 0) and select (bit 1)
    sport_edge #(
        .N    (2),
        .IDLE (2'b10)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({csn_i, sclk_i}),
        .rise_o (edge_rise),
        .fall_o (edge_fall)
    );

    assign sclk_rise = edge_rise[0];
    assign sclk_fall = edge_fall[0];
    assign csn_rise  = edge_rise[1];
    assign sel       = ~csn_i;

    sport_rx #(.W(BYTE_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .rise_i    (sclk_rise),
        .bit_i     (sdi_i),
        .byte_o    (rx_byte),
        .done_o    (rx_done),
        .partial_o (rx_partial)
    );

    assign cmd_read = rx_byte[DIR_BIT];
    assign cmd_long = rx_byte[LEN_BIT];
    assign cmd_addr = rx_byte[ADDR_W-1:0];
    assign abort    = csn_rise && rx_partial;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD: begin
                if (rx_done && cmd_long) begin
                    state_d = cmd_read ? ST_RD_FETCH : ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (rx_done || abort) begin
                    state_d = ST_CMD;
                end
            end
            ST_RD_FETCH: begin
                state_d = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (rx_done || abort) begin
                    state_d = ST_CMD;
                end
            end
            default: state_d = ST_CMD;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wr_data_q <= '0;
            wr_stb_q  <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            unique case (state_q)
                ST_CMD: begin
                    if (rx_done && cmd_long) begin
                        addr_q <= cmd_addr;
                    end
                end
                ST_WR_DATA: begin
                    if (rx_done) begin
                        wr_data_q <= rx_byte;
                        wr_stb_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tx_load  = (state_q == ST_RD_FETCH);
    assign tx_shift = (state_q == ST_RD_DATA) && sel && sclk_fall && rx_partial;

    sport_tx #(.W(BYTE_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tx_load),
        .load_val_i (rd_data_i),
        .shift_i    (tx_shift),
        .bit_o      (sdo_o)
    );

    assign sdo_oe_o   = (state_q == ST_RD_DATA) && sel;
    assign rd_req_o   = (state_q == ST_RD_FETCH);
    assign wr_stb_o   = wr_stb_q;
    assign reg_addr_o = addr_q;
    assign wr_data_o  = wr_data_q;

    // R3
    wr_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R11
    wr_back_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (state_q == ST_CMD));

    // R4
    rd_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> (!rd_req_o && state_q == ST_RD_DATA));

    // R9
    abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_CMD && !wr_stb_o));

    // R8
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && rx_done && !cmd_long) |=> (state_q == ST_CMD && !rd_req_o));

    // R5
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_DATA && !sclk_fall) |=> $stable(sdo_o));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && !csn_rise) |=> !rx_partial);

endmodule

// File: tb/sport_top_tb_top.sv
module sport_top_tb_top;

    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       csn = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo_o, sdo_oe_o, wr_stb_o, rd_req_o;
    logic [5:0] reg_addr_o;
    logic [7:0] wr_data_o;
    logic [7:0] rd_data_i;

    logic [7:0]  mem [64];
    logic [13:0] wq [$];
    int          rd_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sport_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .csn_i      (csn),
        .sdi_i      (sdi),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o),
        .wr_stb_o   (wr_stb_o),
        .rd_req_o   (rd_req_o),
        .reg_addr_o (reg_addr_o),
        .wr_data_o  (wr_data_o),
        .rd_data_i  (rd_data_i)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'((i * 3 + 1) & 255);
    endfunction

    // Register file model on the parallel side
    assign rd_data_i = mem[reg_addr_o];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
        end else begin
            if (wr_stb_o) begin
                wq.push_back({reg_addr_o, wr_data_o});
                mem[reg_addr_o] <= wr_data_o;
            end
            if (rd_req_o) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock model: the output enable must be off whenever select is high (R6)
    always @(negedge clk) begin
        if (rst_n && !done && csn) begin
            chk(!sdo_oe_o, "R6 oe while deselected", int'(sdo_oe_o), 0);
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_lo();
        @(negedge clk);
        csn = 1'b0;
        half();
    endtask

    task automatic sel_hi();
        half();
        csn = 1'b1;
        half();
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n,
                             output logic [7:0] rx, output int oe_n);
        rx = '0;
        oe_n = 0;
        for (int i = 7; i > 7 - n; i--) begin
            sdi = tx[i];
            half();
            rx[i] = sdo_o;
            oe_n += int'(sdo_oe_o);
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output int oe_n);
        send_bits(tx, 8, rx, oe_n);
    endtask

    task automatic expect_write(input string req, input logic [5:0] a, input logic [7:0] d);
        repeat (4) @(negedge clk);
        chk(wq.size() == 1, req, wq.size(), 1);
        if (wq.size() > 0) begin
            chk(wq[0][13:8] == a, req, int'(wq[0][13:8]), int'(a));
            chk(wq[0][7:0] == d, req, int'(wq[0][7:0]), int'(d));
        end
        wq.delete();
    endtask

    task automatic wr_split(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] rx;
        int oe_n;
        sel_lo(); xfer({2'b01, a}, rx, oe_n); sel_hi();
        sel_lo(); xfer(d, rx, oe_n); sel_hi();
    endtask

    task automatic wr_one(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] rx;
        int oe_n;
        sel_lo(); xfer({2'b01, a}, rx, oe_n); xfer(d, rx, oe_n); sel_hi();
    endtask

    task automatic rd_split(input logic [5:0] a, output logic [7:0] got,
                            output int oe_cmd, output int oe_dat);
        logic [7:0] rx;
        sel_lo(); xfer({2'b11, a}, rx, oe_cmd); sel_hi();
        sel_lo(); xfer(8'h00, got, oe_dat); sel_hi();
    endtask

    task automatic rd_one(input logic [5:0] a, output logic [7:0] got);
        logic [7:0] rx;
        int oe_n;
        sel_lo(); xfer({2'b11, a}, rx, oe_n); xfer(8'hFF, got, oe_n); sel_hi();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, rx;
        int oe_c, oe_d, n0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk(!sdo_oe_o, "R1 oe", int'(sdo_oe_o), 0);
        chk(!wr_stb_o, "R1 wr_stb", int'(wr_stb_o), 0);
        chk(!rd_req_o, "R1 rd_req", int'(rd_req_o), 0);

        // R2 R3 R7: split-window write
        wr_split(6'h15, 8'hA5);
        expect_write("R3 split write", 6'h15, 8'hA5);

        // R7: single 16-clock window write
        wr_one(6'h3F, 8'h5A);
        expect_write("R7 one-window write", 6'h3F, 8'h5A);

        // R4 R5 R6: split-window read
        n0 = rd_cnt;
        rd_split(6'h15, got, oe_c, oe_d);
        chk(rd_cnt == n0 + 1, "R4 read request count", rd_cnt - n0, 1);
        chk(got == 8'hA5, "R5 read data", int'(got), 8'hA5);
        chk(oe_c == 0, "R6 oe during command byte", oe_c, 0);
        chk(oe_d == 8, "R6 oe during read data", oe_d, 8);

        // R7 R5: 16-clock read, MSB-first with a single set bit
        wr_one(6'h20, 8'h01);
        wq.delete();
        rd_one(6'h20, got);
        chk(got == 8'h01, "R7 one-window read", int'(got), 8'h01);
        rd_one(6'h3F, got);
        chk(got == 8'h5A, "R5 one-window read", int'(got), 8'h5A);

        // R8: command-only bytes
        n0 = rd_cnt;
        sel_lo(); xfer(8'h05, rx, oe_c); sel_hi();
        sel_lo(); xfer(8'h85, rx, oe_c); sel_hi();
        repeat (4) @(negedge clk);
        chk(wq.size() == 0, "R8 no strobe on command-only", wq.size(), 0);
        chk(rd_cnt == n0, "R8 no read on command-only", rd_cnt - n0, 0);
        wr_split(6'h2A, 8'h3C);
        expect_write("R8 command after resync", 6'h2A, 8'h3C);

        // R9: truncated data byte
        sel_lo(); xfer({2'b01, 6'h11}, rx, oe_c); sel_hi();
        sel_lo(); send_bits(8'hFF, 3, rx, oe_c); sel_hi();
        wr_one(6'h12, 8'h77);
        expect_write("R9 after truncated data", 6'h12, 8'h77);
        rd_one(6'h11, got);
        chk(got == init_val(6'h11), "R9 truncated target untouched", int'(got), int'(init_val(6'h11)));

        // R9: truncated command byte
        sel_lo(); send_bits(8'h7F, 5, rx, oe_c); sel_hi();
        rd_one(6'h12, got);
        chk(got == 8'h77, "R9 after truncated command", int'(got), 8'h77);

        // R9 R6: truncated read data byte
        sel_lo(); xfer({2'b11, 6'h12}, rx, oe_c); send_bits(8'h00, 4, rx, oe_c); sel_hi();
        chk(!sdo_oe_o, "R9 oe after truncated read", int'(sdo_oe_o), 0);
        wr_split(6'h09, 8'h90);
        expect_write("R9 after truncated read", 6'h09, 8'h90);

        // R10: clock edges while deselected
        sdi = 1'b1;
        for (int k = 0; k < 6; k++) begin
            half(); sclk = 1'b1; half(); sclk = 1'b0;
        end
        wr_split(6'h01, 8'h81);
        expect_write("R10 clocks while deselected", 6'h01, 8'h81);

        // R11: back-to-back transactions in one window
        sel_lo();
        xfer({2'b01, 6'h05}, rx, oe_c); xfer(8'hC3, rx, oe_c);
        xfer({2'b01, 6'h06}, rx, oe_c); xfer(8'h3C, rx, oe_c);
        sel_hi();
        repeat (4) @(negedge clk);
        chk(wq.size() == 2, "R11 two writes in one window", wq.size(), 2);
        if (wq.size() == 2) begin
            chk(wq[1] == {6'h06, 8'h3C}, "R11 second write", int'(wq[1]), int'({6'h06, 8'h3C}));
        end
        wq.delete();
        sel_lo();
        xfer({2'b11, 6'h05}, rx, oe_c); xfer(8'hAA, got, oe_d);
        chk(got == 8'hC3, "R11 first read in window", int'(got), 8'hC3);
        xfer({2'b11, 6'h06}, rx, oe_c); xfer(8'h55, got, oe_d);
        chk(got == 8'h3C, "R11 second read in window", int'(got), 8'h3C);
        chk(oe_c == 0, "R6 oe off on second command", oe_c, 0);
        sel_hi();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule